// File: doc/BRIEF.md
# Clock Source Control and Status Register

This block is a single 32-bit control and status word for the clock system of a small microcontroller. It covers three clock sources: an internal RC oscillator, an external crystal oscillator and a PLL. For each source it holds an enable and a ready flag. It also holds a crystal bypass flag, a clock-failure-detector enable, a 6-bit trim and an 8-bit calibration value for the internal oscillator, and an 8-bit key that unlocks calibration writes. Software reaches the word over a simple bus with per-byte write strobes and no wait states. The enable, bypass, trim and calibration outputs drive the oscillators directly.

Hardware events can override what software writes. Entering a low-power mode turns off the crystal and the PLL. Leaving a low-power mode, or a crystal failure, turns the internal oscillator on. A source that is the current system clock cannot be switched off by a write. Each ready flag follows its enable. It rises only after the oscillator has reported stable for a fixed number of cycles, and it drops one cycle after the enable or the stable indication goes away.

Top module: `clkctl_reg`

## Requirements
- R1: A cycle with `bus_sel_i` and `bus_wr_i` high writes, at that clock edge, only the byte lanes whose `bus_be_i` bit is set (lane n is bits 8n+7..8n). `bus_rdata_o` shows the whole word combinationally while `bus_sel_i` is high, and shows 0 while it is low.
- R2: After reset the word reads 0x00008081 with the default calibration value 0x80: internal enable 1, trim 32, calibration equal to the `CAL_INIT` parameter, and every other bit 0.
- R3: Field layout: bit 0 internal enable, bit 1 internal ready, bits 7..2 trim, bits 15..8 calibration, bits 23..16 key, bit 24 crystal enable, bit 25 crystal ready, bit 26 crystal bypass, bit 27 failure-detector enable, bit 28 PLL enable, bit 29 PLL ready. Ready bits ignore writes.
- R4: A cycle with `lp_enter_i` high clears the crystal and PLL enables at that edge.
- R5: `sysclk_src_i` encodes the system clock as 0 internal, 1 crystal, 2 PLL, 3 none. A write of 0 to the enable of the source that is the system clock leaves that enable at 1.
- R6: A cycle with `lp_exit_i` or `xtal_fail_i` high sets the internal oscillator enable at that edge.
- R7: When a hardware event and a write hit the same enable in one cycle, the hardware event decides the result.
- R8: The bypass bit takes a written value only if the crystal enable was 0 before the write, including a write that sets the enable in the same cycle. Otherwise it keeps its value.
- R9: A write to the calibration byte takes effect only if the key field held 0x5A before the write. A key written in the same cycle does not count.
- R10: With an enable at 1 and its `osc_ok_i` bit at 1, the ready bit reads 1 from the (`STABLE_CYCLES`+1)-th clock edge after the edge that set the enable. It reads 0 one edge after the enable or `osc_ok_i` drops.
- R11: Bits 31..30 always read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_sel_i | input | 1 | Access cycle select |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_be_i | input | 4 | Byte write strobes |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational |
| sysclk_src_i | input | 2 | Current system clock source |
| osc_ok_i | input | 3 | Stable indication per source (0 internal, 1 crystal, 2 PLL) |
| lp_enter_i | input | 1 | Low-power entry event |
| lp_exit_i | input | 1 | Low-power exit event |
| xtal_fail_i | input | 1 | Crystal clock failure event |
| osc_en_o | output | 3 | Source enables (0 internal, 1 crystal, 2 PLL) |
| xtal_bypass_o | output | 1 | Crystal bypass |
| cfd_en_o | output | 1 | Clock failure detector enable |
| int_trim_o | output | 6 | Internal oscillator trim |
| int_cal_o | output | 8 | Internal oscillator calibration |

## Verification
Some rules are checked by the assertions on every cycle: the enable protection for the system clock, the hardware clear on low-power entry and the hardware set on exit or failure, the bypass and calibration locks, ready falling after its enable, and the reserved bits. Other behaviour can only be shown by the bench scenarios. These cover the exact edge on which a ready bit rises, byte-lane selection, the same-cycle conflicts between a write and a hardware event, and the rule that a key or enable written in the same word does not count.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

  typedef enum logic [1:0] {
    SRC_INT  = 2'd0,
    SRC_XTAL = 2'd1,
    SRC_PLL  = 2'd2,
    SRC_NONE = 2'd3
  } clk_src_e;

  localparam int NSRC      = 3;
  localparam int BIT_INT_EN  = 0;
  localparam int BIT_INT_RDY = 1;
  localparam int TRIM_LSB    = 2;
  localparam int TRIM_W      = 6;
  localparam int CAL_LSB     = 8;
  localparam int CAL_W       = 8;
  localparam int KEY_LSB     = 16;
  localparam int KEY_W       = 8;
  localparam int BIT_XT_EN   = 24;
  localparam int BIT_XT_RDY  = 25;
  localparam int BIT_XT_BYP  = 26;
  localparam int BIT_CFD     = 27;
  localparam int BIT_PLL_EN  = 28;
  localparam int BIT_PLL_RDY = 29;

  localparam logic [KEY_W-1:0]  CAL_UNLOCK = 8'h5A;
  localparam logic [TRIM_W-1:0] TRIM_RST   = 6'd32;

  // enable bit position of source i (0 internal, 1 crystal, 2 pll)
  function automatic int en_pos(int i);
    case (i)
      0:       return BIT_INT_EN;
      1:       return BIT_XT_EN;
      default: return BIT_PLL_EN;
    endcase
  endfunction

endpackage

// File: rtl/clkctl_rst_sync.sv
module clkctl_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/clkctl_enable_bit.sv
module clkctl_enable_bit #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_en_i,
  input  logic wr_val_i,
  input  logic protect_i,
  input  logic hw_set_i,
  input  logic hw_clr_i,
  output logic en_o
);
  logic en_q, en_d;

  // hardware events take priority over any software write
  always_comb begin
    en_d = en_q;
    if (hw_set_i)                                   en_d = 1'b1;
    else if (hw_clr_i)                              en_d = 1'b0;
    else if (wr_en_i && !(protect_i && !wr_val_i))  en_d = wr_val_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= RST_VAL;
    else         en_q <= en_d;
  end

  assign en_o = en_q;
endmodule

// File: rtl/clkctl_ready_timer.sv
module clkctl_ready_timer #(
  parameter int STABLE_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic osc_ok_i,
  output logic rdy_o
);
  localparam int CNT_W = $clog2(STABLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(STABLE_CYCLES);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             rdy_q, rdy_d;
  logic             run;
  logic             done;

  assign run  = en_i & osc_ok_i;
  assign done = (cnt_q == CNT_MAX);

  always_comb begin
    cnt_d = cnt_q;
    if (!run)       cnt_d = '0;
    else if (!done) cnt_d = cnt_q + 1'b1;
    rdy_d = run & done;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      rdy_q <= rdy_d;
    end
  end

  assign rdy_o = rdy_q;
endmodule

// File: rtl/clkctl_field.sv
module clkctl_field #(
  parameter int             W       = 8,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q, d;

  always_comb d = we_i ? d_i : q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= RST_VAL;
    else         q <= d;
  end

  assign q_o = q;
endmodule

// File: rtl/clkctl_reg.sv
module clkctl_reg #(
  parameter int         STABLE_CYCLES = 16,
  parameter logic [7:0] CAL_INIT      = 8'h80
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bus_sel_i,
  input  logic        bus_wr_i,
  input  logic [3:0]  bus_be_i,
  input  logic [31:0] bus_wdata_i,
  output logic [31:0] bus_rdata_o,
  input  logic [1:0]  sysclk_src_i,
  input  logic [2:0]  osc_ok_i,
  input  logic        lp_enter_i,
  input  logic        lp_exit_i,
  input  logic        xtal_fail_i,
  output logic [2:0]  osc_en_o,
  output logic        xtal_bypass_o,
  output logic        cfd_en_o,
  output logic [5:0]  int_trim_o,
  output logic [7:0]  int_cal_o
);
  import clkctl_pkg::*;

  localparam int LANES = 4;

  logic                   rst_n_s;
  logic [LANES-1:0]       lane_we;
  logic [NSRC-1:0]        osc_en;
  logic [NSRC-1:0]        osc_rdy;
  logic [NSRC-1:0]        hw_set;
  logic [NSRC-1:0]        hw_clr;
  logic [TRIM_W-1:0]      trim_q;
  logic [CAL_W-1:0]       cal_q;
  logic [KEY_W-1:0]       key_q;
  logic                   byp_q;
  logic                   cfd_q;
  logic                   cal_we;
  logic                   byp_we;
  logic [31:0]            word;
  logic                   unused_wbits;

  clkctl_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_s)
  );

  assign lane_we = {LANES{bus_sel_i & bus_wr_i}} & bus_be_i;

  assign hw_set = {1'b0, 1'b0, lp_exit_i | xtal_fail_i};
  assign hw_clr = {lp_enter_i, lp_enter_i, 1'b0};

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    localparam int POS = en_pos(g);
    localparam logic RST_EN = (g == 0) ? 1'b1 : 1'b0;

    clkctl_enable_bit #(.RST_VAL(RST_EN)) u_en (
      .clk_i     (clk_i),
      .rst_ni    (rst_n_s),
      .wr_en_i   (lane_we[POS/8]),
      .wr_val_i  (bus_wdata_i[POS]),
      .protect_i (sysclk_src_i == 2'(g)),
      .hw_set_i  (hw_set[g]),
      .hw_clr_i  (hw_clr[g]),
      .en_o      (osc_en[g])
    );

    clkctl_ready_timer #(.STABLE_CYCLES(STABLE_CYCLES)) u_rdy (
      .clk_i    (clk_i),
      .rst_ni   (rst_n_s),
      .en_i     (osc_en[g]),
      .osc_ok_i (osc_ok_i[g]),
      .rdy_o    (osc_rdy[g])
    );
  end

  clkctl_field #(.W(TRIM_W), .RST_VAL(TRIM_RST)) u_trim (
    .clk_i  (clk_i),
    .rst_ni (rst_n_s),
    .we_i   (lane_we[TRIM_LSB/8]),
    .d_i    (bus_wdata_i[TRIM_LSB +: TRIM_W]),
    .q_o    (trim_q)
  );

  assign cal_we = lane_we[CAL_LSB/8] && (key_q == CAL_UNLOCK);

  clkctl_field #(.W(CAL_W), .RST_VAL(CAL_INIT)) u_cal (
    .clk_i  (clk_i),
    .rst_ni (rst_n_s),
    .we_i   (cal_we),
    .d_i    (bus_wdata_i[CAL_LSB +: CAL_W]),
    .q_o    (cal_q)
  );

  clkctl_field #(.W(KEY_W), .RST_VAL('0)) u_key (
    .clk_i  (clk_i),
    .rst_ni (rst_n_s),
    .we_i   (lane_we[KEY_LSB/8]),
    .d_i    (bus_wdata_i[KEY_LSB +: KEY_W]),
    .q_o    (key_q)
  );

  assign byp_we = lane_we[BIT_XT_BYP/8] && !osc_en[1];

  clkctl_field #(.W(1), .RST_VAL(1'b0)) u_byp (
    .clk_i  (clk_i),
    .rst_ni (rst_n_s),
    .we_i   (byp_we),
    .d_i    (bus_wdata_i[BIT_XT_BYP]),
    .q_o    (byp_q)
  );

  clkctl_field #(.W(1), .RST_VAL(1'b0)) u_cfd (
    .clk_i  (clk_i),
    .rst_ni (rst_n_s),
    .we_i   (lane_we[BIT_CFD/8]),
    .d_i    (bus_wdata_i[BIT_CFD]),
    .q_o    (cfd_q)
  );

  always_comb begin
    word                              = '0;
    word[BIT_INT_EN]                  = osc_en[0];
    word[BIT_INT_RDY]                 = osc_rdy[0];
    word[TRIM_LSB +: TRIM_W]          = trim_q;
    word[CAL_LSB +: CAL_W]            = cal_q;
    word[KEY_LSB +: KEY_W]            = key_q;
    word[BIT_XT_EN]                   = osc_en[1];
    word[BIT_XT_RDY]                  = osc_rdy[1];
    word[BIT_XT_BYP]                  = byp_q;
    word[BIT_CFD]                     = cfd_q;
    word[BIT_PLL_EN]                  = osc_en[2];
    word[BIT_PLL_RDY]                 = osc_rdy[2];
  end

  assign bus_rdata_o = bus_sel_i ? word : '0;

  assign unused_wbits = ^{bus_wdata_i[31:29], bus_wdata_i[25], bus_wdata_i[1]};

  assign osc_en_o      = osc_en;
  assign xtal_bypass_o = byp_q;
  assign cfd_en_o      = cfd_q;
  assign int_trim_o    = trim_q;
  assign int_cal_o     = cal_q;
endmodule

// File: rtl/clkctl_reg_chk.sv
module clkctl_reg_chk (
  input logic        clk_i,
  input logic        rst_n,
  input logic [1:0]  sysclk,
  input logic        lp_enter,
  input logic        lp_exit,
  input logic        xtal_fail,
  input logic [2:0]  en,
  input logic [2:0]  rdy,
  input logic        bypass,
  input logic [7:0]  cal,
  input logic [7:0]  key,
  input logic [31:0] rdata
);
  assert_int_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    (en[0] && sysclk == 2'd0) |=> en[0]);
  assert_xtal_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    (en[1] && sysclk == 2'd1 && !lp_enter) |=> en[1]);
  assert_pll_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    (en[2] && sysclk == 2'd2 && !lp_enter) |=> en[2]);
  // also covers R7: a same-cycle write cannot keep these enables on
  assert_lp_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
    lp_enter |=> (!en[1] && !en[2]));
  // also covers R7: a same-cycle write cannot clear the internal enable
  assert_int_wake_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    (lp_exit || xtal_fail) |=> en[0]);
  assert_bypass_lock_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
    en[1] |=> $stable(bypass));
  assert_cal_lock_R9: assert property (@(posedge clk_i) disable iff (!rst_n)
    (key != 8'h5A) |=> $stable(cal));
  assert_int_rdy_drop_R10: assert property (@(posedge clk_i) disable iff (!rst_n)
    !en[0] |=> !rdy[0]);
  assert_xtal_rdy_drop_R10: assert property (@(posedge clk_i) disable iff (!rst_n)
    !en[1] |=> !rdy[1]);
  assert_pll_rdy_drop_R10: assert property (@(posedge clk_i) disable iff (!rst_n)
    !en[2] |=> !rdy[2]);
  assert_pll_rdy_rise_R10: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(rdy[2]) |-> $past(en[2]));
  assert_reserved_R11: assert property (@(posedge clk_i) disable iff (!rst_n)
    rdata[31:30] == 2'b00);
endmodule

bind clkctl_reg clkctl_reg_chk u_chk (
  .clk_i     (clk_i),
  .rst_n     (rst_n_s),
  .sysclk    (sysclk_src_i),
  .lp_enter  (lp_enter_i),
  .lp_exit   (lp_exit_i),
  .xtal_fail (xtal_fail_i),
  .en        (osc_en),
  .rdy       (osc_rdy),
  .bypass    (byp_q),
  .cal       (cal_q),
  .key       (key_q),
  .rdata     (bus_rdata_o)
);

// File: tb/clkctl_reg_test.sv
module clkctl_reg_test;
  localparam int STABLE = 16;
  localparam logic [31:0] NORDY = ~32'h2200_0002;

  logic        clk;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [3:0]  bus_be;
  logic [31:0] bus_wdata, bus_rdata;
  logic [1:0]  sysclk;
  logic [2:0]  osc_ok;
  logic        lp_enter, lp_exit, xtal_fail;
  logic [2:0]  osc_en;
  logic        xtal_bypass, cfd_en;
  logic [5:0]  int_trim;
  logic [7:0]  int_cal;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [31:0] exp_q[$];
  logic [31:0] msk_q[$];
  string       tag_q[$];

  clkctl_reg #(.STABLE_CYCLES(STABLE), .CAL_INIT(8'h80)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_sel_i(bus_sel), .bus_wr_i(bus_wr), .bus_be_i(bus_be),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .sysclk_src_i(sysclk), .osc_ok_i(osc_ok),
    .lp_enter_i(lp_enter), .lp_exit_i(lp_exit), .xtal_fail_i(xtal_fail),
    .osc_en_o(osc_en), .xtal_bypass_o(xtal_bypass), .cfd_en_o(cfd_en),
    .int_trim_o(int_trim), .int_cal_o(int_cal)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic void check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endfunction

  // monitor: pops one expected item per read cycle
  always @(negedge clk) begin
    if (bus_sel && !bus_wr && exp_q.size() > 0) begin
      logic [31:0] e, m;
      string t;
      e = exp_q.pop_front();
      m = msk_q.pop_front();
      t = tag_q.pop_front();
      check(t, bus_rdata & m, e & m);
    end
  end

  task automatic push(string tag, logic [31:0] exp, logic [31:0] msk);
    exp_q.push_back(exp);
    msk_q.push_back(msk);
    tag_q.push_back(tag);
  endtask

  task automatic rd(string tag, logic [31:0] exp, logic [31:0] msk);
    @(posedge clk); #1;
    push(tag, exp, msk);
    bus_sel = 1'b1; bus_wr = 1'b0;
    @(posedge clk); #1;
    bus_sel = 1'b0;
  endtask

  task automatic wr(logic [3:0] be, logic [31:0] d);
    @(posedge clk); #1;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_be = be; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0; bus_be = '0;
  endtask

  // ev: {lp_enter, lp_exit, xtal_fail}; optional same-cycle write
  task automatic event_pulse(logic [2:0] ev, logic do_wr, logic [3:0] be, logic [31:0] d);
    @(posedge clk); #1;
    {lp_enter, lp_exit, xtal_fail} = ev;
    if (do_wr) begin
      bus_sel = 1'b1; bus_wr = 1'b1; bus_be = be; bus_wdata = d;
    end
    @(posedge clk); #1;
    {lp_enter, lp_exit, xtal_fail} = 3'b000;
    bus_sel = 1'b0; bus_wr = 1'b0; bus_be = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_sel = 0; bus_wr = 0; bus_be = '0; bus_wdata = '0;
    sysclk = 2'd0; osc_ok = 3'b111; lp_enter = 0; lp_exit = 0; xtal_fail = 0;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);

    rd("R2 reset word", 32'h0000_8081, NORDY);
    repeat (20) @(posedge clk);
    rd("R10 internal ready after reset", 32'h0000_0002, 32'h0000_0002);

    // R1 byte lanes, R3 ready bit ignores writes
    wr(4'b0001, 32'h0000_00FD);
    rd("R1 lane0 only", 32'h0000_80FD, NORDY);
    wr(4'b0100, 32'hFFFF_FFFF);
    rd("R1 lane2 only", 32'h00FF_80FD, NORDY);

    // R9 calibration key gate
    wr(4'b0010, 32'h0000_1200);
    rd("R9 cal locked", 32'h00FF_80FD, NORDY);
    wr(4'b0100, 32'h005A_0000);
    wr(4'b0010, 32'h0000_1200);
    rd("R9 cal unlocked", 32'h005A_12FD, NORDY);
    wr(4'b0100, 32'h0000_0000);
    wr(4'b0110, 32'h005A_3400);
    rd("R9 same-word key ignored", 32'h005A_12FD, NORDY);

    // R8 bypass lock
    wr(4'b1000, 32'h0500_0000);
    rd("R8 bypass set with enable", 32'h055A_12FD, NORDY);
    wr(4'b1000, 32'h0900_0000);
    rd("R8 bypass held while enabled", 32'h0D5A_12FD, NORDY);

    // R5 protection
    sysclk = 2'd1;
    wr(4'b1000, 32'h0800_0000);
    rd("R5 crystal enable protected", 32'h0D5A_12FD, NORDY);
    wr(4'b0001, 32'h0000_00FC);
    rd("R5 internal clear allowed", 32'h0D5A_12FC, NORDY);
    wr(4'b0001, 32'h0000_00FD);
    sysclk = 2'd0;
    wr(4'b0001, 32'h0000_00FC);
    rd("R5 internal enable protected", 32'h0D5A_12FD, NORDY);

    // R10 PLL ready rise timing
    wr(4'b1000, 32'h1D00_0000);
    bus_sel = 1'b1; bus_wr = 1'b0;
    for (int k = 0; k <= STABLE + 1; k++) begin
      push("R10 pll ready rise", (k >= STABLE + 1) ? 32'h2000_0000 : 32'h0, 32'h2000_0000);
      @(posedge clk); #1;
    end
    bus_sel = 1'b0;
    rd("R3 pll enabled word", 32'h1D5A_12FD, NORDY);

    sysclk = 2'd2;
    wr(4'b1000, 32'h0D00_0000);
    rd("R5 pll enable protected", 32'h3D5A_12FD, ~32'h0200_0002);
    sysclk = 2'd0;
    wr(4'b1000, 32'h0D00_0000);
    bus_sel = 1'b1; bus_wr = 1'b0;
    push("R10 pll ready holds one edge", 32'h2000_0000, 32'h2000_0000);
    @(posedge clk); #1;
    push("R10 pll ready drop", 32'h0, 32'h2000_0000);
    @(posedge clk); #1;
    bus_sel = 1'b0;

    // R4 low-power entry
    wr(4'b1000, 32'h1D00_0000);
    event_pulse(3'b100, 1'b0, 4'b0000, 32'h0);
    rd("R4 lp entry clears", 32'h0C5A_12FD, NORDY);

    // R6 internal wake
    sysclk = 2'd1;
    wr(4'b0001, 32'h0000_00FC);
    rd("R6 internal off", 32'h0C5A_12FC, NORDY);
    event_pulse(3'b010, 1'b0, 4'b0000, 32'h0);
    rd("R6 lp exit sets", 32'h0C5A_12FD, NORDY);
    wr(4'b0001, 32'h0000_00FC);
    event_pulse(3'b001, 1'b0, 4'b0000, 32'h0);
    rd("R6 crystal failure sets", 32'h0C5A_12FD, NORDY);

    // R7 conflicts
    event_pulse(3'b001, 1'b1, 4'b0001, 32'h0000_00FC);
    rd("R7 failure beats clear", 32'h0C5A_12FD, NORDY);
    event_pulse(3'b100, 1'b1, 4'b1000, 32'h0D00_0000);
    rd("R7 lp entry beats set", 32'h0C5A_12FD, NORDY);
    wr(4'b1000, 32'h0800_0000);
    rd("R8 bypass clears when disabled", 32'h085A_12FD, NORDY);

    // R11 reserved
    wr(4'b1000, 32'hFF00_0000);
    rd("R11 top byte", 32'h1D5A_12FD, NORDY);
    rd("R11 reserved zero", 32'h0, 32'hC000_0000);

    // R1 unselected read data
    @(negedge clk);
    check("R1 idle rdata zero", bus_rdata, 32'h0);

    // R10 osc_ok drop
    osc_ok = 3'b110;
    repeat (3) @(posedge clk);
    rd("R10 internal ready drops", 32'h0, 32'h0000_0002);
    osc_ok = 3'b111;

    repeat (3) @(posedge clk);
    if (exp_q.size() != 0) check("R1 pending reads", exp_q.size(), 0);
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule